// File: doc/BRIEF.md
# Thread-Aware Shared Queue Entry Allocator

This block decides, cycle by cycle, which logical processors may claim an entry in a queue that they all share, such as a micro-op queue or an instruction scheduler. Each thread raises a one-cycle allocate request and the block answers in the same cycle with a grant. Each thread also sends release pulses as its entries drain. The block keeps an occupancy count for every thread and a derived total. It never holds the payload.

A two-bit policy input selects how the shared capacity is divided. Under the split policy every thread owns an equal slice of the capacity. Under the capped policy a thread may take any free entry until its own count reaches a programmable cap. Under the open policy only the total capacity limits a thread. When more eligible threads ask than there are free entries, the grants rotate fairly among them. A per-thread clear empties one thread's share after a flush. A sticky error flag records any release that arrives while that thread holds nothing.

Top module: `tq_alloc`

## Requirements
- R1: After reset every thread count is zero, no grant is given while no request is raised, every `full_o` bit is 0 and `err_o` is 0.
- R2: With `policy_i` = 0 (split), the limit of each thread is CAPACITY/NUM_THR. A thread that holds that many entries has its `full_o` bit set and is not granted.
- R3: With `policy_i` = 1 (capped), the limit of each thread is `cap_i`. A thread stops being granted once its count equals `cap_i`.
- R4: A `cap_i` value above CAPACITY acts as CAPACITY.
- R5: With `policy_i` = 2 or 3 (open), a single thread can be granted every one of the CAPACITY entries. Once the total reaches CAPACITY, every `full_o` bit is 1.
- R6: `full_o[t]` is 0 exactly when the total count is below CAPACITY and thread t's count is below its policy limit. An eligible request is granted in the same cycle, and the grant adds one to the count at the next clock edge.
- R7: When more eligible threads request than there are free entries, the free entries go to the requesters in increasing index order, wrapping around, starting with the thread after the one granted most recently. The most recently granted thread is the last one granted in the previous cycle that had any grant. At reset that pointer is thread NUM_THR-1.
- R8: A granted allocate and a release for the same thread in the same cycle leave that thread's count unchanged. A release alone lowers the count by one.
- R9: `clr_i[t]` sets thread t's count to zero at the next edge. It suppresses thread t's grant and release in that cycle and leaves the other threads' counts untouched.
- R10: A release to a thread whose count is zero is ignored and sets `err_o`. `err_o` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | 0 split, 1 capped, 2 or 3 open |
| cap_i | input | CW = $clog2(CAPACITY+1) | Per-thread cap for the capped policy |
| req_i | input | NUM_THR | Per-thread allocate request |
| rel_i | input | NUM_THR | Per-thread release pulse |
| clr_i | input | NUM_THR | Per-thread occupancy clear |
| gnt_o | output | NUM_THR | Per-thread grant, same cycle as the request |
| full_o | output | NUM_THR | Per-thread full indication |
| err_o | output | 1 | Sticky release-while-empty error |

## Verification
The bench builds the block with NUM_THR = 3 and CAPACITY = 6. This gives a split slice of 2 entries and lets a single thread fill the whole pool within a few cycles. With three threads the rotation truly wraps, so the round-robin order can be told apart from a fixed priority. A 3-bit cap port can carry the value 7, which is above the capacity, so the clamp of R4 can be reached. Counts are read back through the ports: the bench switches to the capped policy for a moment and sweeps `cap_i` while it watches `full_o`.

// File: rtl/tq_pkg.sv
package tq_pkg;

   typedef enum logic [1:0] {
      POL_SPLIT = 2'd0,
      POL_CAP   = 2'd1,
      POL_OPEN  = 2'd2,
      POL_OPEN2 = 2'd3
   } tq_policy_e;

endpackage

// File: rtl/tq_limit_sel.sv
module tq_limit_sel
   import tq_pkg::*;
#(
   parameter int NUM_THR  = 2,
   parameter int CAPACITY = 16,
   localparam int CW      = $clog2(CAPACITY + 1)
) (
   input  logic [1:0]    policy_i,
   input  logic [CW-1:0] cap_i,
   output logic [CW-1:0] limit_o
);

   localparam int SLICE = CAPACITY / NUM_THR;
   localparam logic [CW-1:0] SLICE_V = CW'(SLICE);
   localparam logic [CW-1:0] CAP_V   = CW'(CAPACITY);

   tq_policy_e pol;
   logic [CW-1:0] cap_clamped;

   assign pol = tq_policy_e'(policy_i);

   always_comb begin
      if (cap_i > CAP_V) cap_clamped = CAP_V;
      else               cap_clamped = cap_i;
   end

   always_comb begin
      unique case (pol)
         POL_SPLIT: limit_o = SLICE_V;
         POL_CAP:   limit_o = cap_clamped;
         default:   limit_o = CAP_V;
      endcase
   end

   always_comb begin
      assert (limit_o <= CAP_V) else $error("p_limit_in_range_r4");
   end

endmodule

// File: rtl/tq_thread_ctr.sv
module tq_thread_ctr #(
   parameter int CAPACITY = 16,
   localparam int CW      = $clog2(CAPACITY + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc_i,
   input  logic          dec_i,
   input  logic          clr_i,
   output logic [CW-1:0] cnt_o,
   output logic          underflow_o
);

   logic dec_ok;

   assign dec_ok      = dec_i && (cnt_o != '0) && !clr_i;
   assign underflow_o = dec_i && (cnt_o == '0) && !clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (clr_i) begin
         cnt_o <= '0;
      end else begin
         unique case ({inc_i, dec_ok})
            2'b10:   cnt_o <= cnt_o + 1'b1;
            2'b01:   cnt_o <= cnt_o - 1'b1;
            default: cnt_o <= cnt_o;
         endcase
      end
   end

   // R9: clear empties the counter at the next edge
   p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_o == '0));

   // R8: allocate and release together hold the count
   p_inc_dec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && dec_i && !clr_i && cnt_o != '0) |=> $stable(cnt_o));

   // R10: release on an empty counter does not wrap
   p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !inc_i && cnt_o == '0) |=> (cnt_o == '0));

endmodule

// File: rtl/tq_rr_grant.sv
module tq_rr_grant #(
   parameter int NUM_THR  = 2,
   parameter int CAPACITY = 16,
   localparam int CW      = $clog2(CAPACITY + 1),
   localparam int PW      = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_THR-1:0] elig_i,
   input  logic [CW-1:0]      free_i,
   output logic [NUM_THR-1:0] gnt_o
);

   logic [PW-1:0] last_q;
   logic [PW-1:0] last_d;

   always_comb begin
      int given;
      int idx;
      gnt_o  = '0;
      last_d = last_q;
      given  = 0;
      for (int k = 1; k <= NUM_THR; k++) begin
         idx = int'(last_q) + k;
         if (idx >= NUM_THR) idx = idx - NUM_THR;
         if (elig_i[idx] && (given < int'(free_i))) begin
            gnt_o[idx] = 1'b1;
            given      = given + 1;
            last_d     = PW'(idx);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= PW'(NUM_THR - 1);
      else        last_q <= last_d;
   end

   // R7: never more grants than free entries
   p_grants_fit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gnt_o) <= int'(free_i));

   // R6: only eligible threads are granted
   p_gnt_elig_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o & ~elig_i) == '0);

endmodule

// File: rtl/tq_alloc.sv
module tq_alloc
   import tq_pkg::*;
#(
   parameter int NUM_THR  = 2,
   parameter int CAPACITY = 16,
   localparam int CW      = $clog2(CAPACITY + 1),
   localparam int TW      = CW + $clog2(NUM_THR + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         policy_i,
   input  logic [CW-1:0]      cap_i,
   input  logic [NUM_THR-1:0] req_i,
   input  logic [NUM_THR-1:0] rel_i,
   input  logic [NUM_THR-1:0] clr_i,
   output logic [NUM_THR-1:0] gnt_o,
   output logic [NUM_THR-1:0] full_o,
   output logic               err_o
);

   if (NUM_THR < 2) begin : g_bad_thr
      $error("tq_alloc: NUM_THR must be at least 2");
   end
   if (CAPACITY < NUM_THR) begin : g_bad_cap
      $error("tq_alloc: CAPACITY must be at least NUM_THR");
   end
   if ((CAPACITY % NUM_THR) != 0) begin : g_bad_div
      $error("tq_alloc: CAPACITY must divide evenly by NUM_THR");
   end

   localparam logic [TW-1:0] CAP_T = TW'(CAPACITY);

   logic [CW-1:0]      cnt   [NUM_THR];
   logic [NUM_THR-1:0] uflow;
   logic [NUM_THR-1:0] elig;
   logic [CW-1:0]      limit;
   logic [TW-1:0]      total;
   logic [CW-1:0]      free;

   tq_limit_sel #(.NUM_THR(NUM_THR), .CAPACITY(CAPACITY)) u_limit (
      .policy_i (policy_i),
      .cap_i    (cap_i),
      .limit_o  (limit)
   );

   always_comb begin
      total = '0;
      for (int t = 0; t < NUM_THR; t++) total = total + TW'(cnt[t]);
   end

   assign free = (total >= CAP_T) ? '0 : CW'(CAP_T - total);

   for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      assign full_o[t] = !((total < CAP_T) && (cnt[t] < limit));
      assign elig[t]   = req_i[t] && !full_o[t] && !clr_i[t];

      tq_thread_ctr #(.CAPACITY(CAPACITY)) u_ctr (
         .clk         (clk),
         .rst_n       (rst_n),
         .inc_i       (gnt_o[t]),
         .dec_i       (rel_i[t]),
         .clr_i       (clr_i[t]),
         .cnt_o       (cnt[t]),
         .underflow_o (uflow[t])
      );

      // R6: a full thread is never granted
      p_gnt_not_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_o[t] |-> !full_o[t]);
   end

   tq_rr_grant #(.NUM_THR(NUM_THR), .CAPACITY(CAPACITY)) u_rr (
      .clk    (clk),
      .rst_n  (rst_n),
      .elig_i (elig),
      .free_i (free),
      .gnt_o  (gnt_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      err_o <= 1'b0;
      else if (|uflow) err_o <= 1'b1;
   end

   // R5: occupancy never passes the capacity
   p_total_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      total <= CAP_T);

   // R10: the error flag is sticky
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R5: a full pool marks every thread full
   p_pool_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (total == CAP_T) |-> (&full_o));

endmodule

// File: tb/tb_tq_alloc.sv
module tb_tq_alloc;

   localparam int N   = 3;
   localparam int CAP = 6;
   localparam int CW  = $clog2(CAP + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    policy = 2'd0;
   logic [CW-1:0] cap = '0;
   logic [N-1:0]  req = '0;
   logic [N-1:0]  rel = '0;
   logic [N-1:0]  clr = '0;
   logic [N-1:0]  gnt;
   logic [N-1:0]  full;
   logic          err;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   tq_alloc #(.NUM_THR(N), .CAPACITY(CAP)) dut (
      .clk(clk), .rst_n(rst_n), .policy_i(policy), .cap_i(cap),
      .req_i(req), .rel_i(rel), .clr_i(clr),
      .gnt_o(gnt), .full_o(full), .err_o(err)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, check grant before the rising edge
   task automatic step(input logic [N-1:0] r, input logic [N-1:0] l,
                       input logic [N-1:0] c, input int exp_gnt, input string tag);
      @(negedge clk);
      req = r; rel = l; clr = c;
      #2;
      check(tag, int'(gnt), exp_gnt);
      @(posedge clk);
      #1;
      req = '0; rel = '0; clr = '0;
   endtask

   // read a thread count through the capped policy and full_o
   task automatic probe(input int t, output int c);
      logic [1:0]    sp;
      logic [CW-1:0] sc;
      @(negedge clk);
      sp = policy; sc = cap;
      req = '0; rel = '0; clr = '0;
      policy = 2'd1;
      c = 0;
      for (int lim = 1; lim <= CAP; lim++) begin
         cap = CW'(lim);
         #1;
         if (full[t]) c++;
      end
      policy = sp; cap = sc;
   endtask

   task automatic expect_cnt(input int t, input int exp, input string tag);
      int c;
      probe(t, c);
      check(tag, c, exp);
   endtask

   task automatic clear_all();
      step('0, '0, '1, 0, "clear");
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 gnt idle", int'(gnt), 0);
      check("R1 full", int'(full), 0);
      check("R1 err", int'(err), 0);
      for (int t = 0; t < N; t++) expect_cnt(t, 0, "R1 count");
   endtask

   task automatic t_split();
      policy = 2'd0;
      step(3'b010, '0, '0, 3'b010, "R2 grant 1");
      step(3'b010, '0, '0, 3'b010, "R2 grant 2");
      @(negedge clk);
      check("R2 full at slice", int'(full[1]), 1);
      check("R6 others open", int'(full[0]), 0);
      step(3'b010, '0, '0, 3'b000, "R2 refused at slice");
      expect_cnt(1, 2, "R2 count");
      clear_all();
   endtask

   task automatic t_capped();
      policy = 2'd1; cap = CW'(3);
      step(3'b001, '0, '0, 3'b001, "R3 grant a");
      step(3'b001, '0, '0, 3'b001, "R3 grant b");
      step(3'b001, '0, '0, 3'b001, "R3 grant c");
      step(3'b001, '0, '0, 3'b000, "R3 refused at cap");
      expect_cnt(0, 3, "R3 count");
      clear_all();
      cap = CW'(7);
      for (int i = 0; i < CAP; i++) step(3'b100, '0, '0, 3'b100, "R4 clamp grant");
      step(3'b100, '0, '0, 3'b000, "R4 refused at capacity");
      @(negedge clk);
      check("R5 all full", int'(full), 7);
      clear_all();
   endtask

   task automatic t_open();
      policy = 2'd2;
      for (int i = 0; i < CAP; i++) step(3'b001, '0, '0, 3'b001, "R5 open grant");
      step(3'b011, '0, '0, 3'b000, "R5 pool exhausted");
      @(negedge clk);
      check("R5 full flags", int'(full), 7);
      clear_all();
      policy = 2'd3;
      for (int i = 0; i < 4; i++) step(3'b010, '0, '0, 3'b010, "R5 alt code grant");
      expect_cnt(1, 4, "R5 alt count");
      clear_all();
   endtask

   task automatic t_hold_clear();
      policy = 2'd2;
      step(3'b001, '0, '0, 3'b001, "R8 prep a");
      step(3'b001, '0, '0, 3'b001, "R8 prep b");
      step(3'b001, 3'b001, '0, 3'b001, "R8 alloc+rel grant");
      expect_cnt(0, 2, "R8 count held");
      step('0, 3'b001, '0, 0, "R8 release");
      expect_cnt(0, 1, "R8 release lowers");
      step(3'b010, '0, '0, 3'b010, "R9 prep a");
      step(3'b010, '0, '0, 3'b010, "R9 prep b");
      step(3'b011, '0, 3'b001, 3'b010, "R9 clear masks grant");
      expect_cnt(0, 0, "R9 cleared");
      expect_cnt(1, 3, "R9 neighbour kept");
      clear_all();
   endtask

   task automatic t_err();
      @(negedge clk);
      check("R10 err low", int'(err), 0);
      step('0, 3'b100, '0, 0, "R10 empty release");
      @(negedge clk);
      check("R10 err set", int'(err), 1);
      expect_cnt(2, 0, "R10 count stays zero");
      step(3'b100, '0, '0, 3'b100, "R10 later grant");
      @(negedge clk);
      check("R10 err sticky", int'(err), 1);
      clear_all();
   endtask

   task automatic t_rr();
      policy = 2'd2;
      for (int i = 0; i < 4; i++) step(3'b001, '0, '0, 3'b001, "R7 fill");
      step(3'b111, '0, '0, 3'b110, "R7 two free after t0");
      step('0, 3'b001, '0, 0, "R7 free one");
      step(3'b111, '0, '0, 3'b001, "R7 wrap to t0");
      step('0, 3'b100, '0, 0, "R7 free one more");
      step(3'b111, '0, '0, 3'b010, "R7 next is t1");
      clear_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_split();
      t_capped();
      t_open();
      t_hold_clear();
      t_rr();
      t_err();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule